// File: doc/BRIEF.md
# Prioritised Interrupt Identifier Unit

This block collects interrupt causes from a set of numbered message slots and one status cause, and presents the CPU with a 16-bit identifier naming the most urgent pending cause together with a single interrupt line. Slot causes are posted when a slot completes a transmit or a receive and that slot's matching interrupt enable is set. The status cause is posted when the protocol engine updates the status register: a successful-transfer update counts only while the status-update enable is set, and an error or state-change update counts only while the error enable is set.

The identifier always reports the cause with the highest priority. It does not report the oldest cause. The status cause outranks every slot. Among slots, the lower slot number wins. Software clears a slot cause by clearing that slot's pending bit. It clears the status cause by reading the status register. Once a cause is cleared, the identifier moves on to the next cause by priority. The interrupt line is this identifier combined with a global interrupt enable.

Top module: `irq_id_top`

## Requirements
- R1: During and right after reset, `intId` is 0x0000, `pendVec` is all zero and `irqOut` is 0.
- R2: Bit i of `pendVec` belongs to slot number i+1. It becomes 1 when `slotTxDone[i]` arrives while `slotTxIe[i]` is 1, or when `slotRxDone[i]` arrives while `slotRxIe[i]` is 1. A completion whose own enable is 0 leaves the bit unchanged.
- R3: When no status cause is pending, `intId` equals the slot number (bit index plus 1) of the lowest-numbered pending slot. The order in which slots became pending has no effect. The highest slot, number NUM_SLOTS, is reported as NUM_SLOTS.
- R4: While a status cause is pending, `intId` is 0x8000, whatever slots are pending.
- R5: `statOkUpd` posts the status cause only while `ctlSie` is 1. `statErrUpd` posts it only while `ctlEie` is 1.
- R6: A status access with `statWrite`=0 (a read) clears the status cause. A status access with `statWrite`=1 (a write) neither clears nor posts it.
- R7: A 1 on `slotClr[i]` clears pending bit i. `intId` then shows the next pending cause by priority, or 0x0000 when none is left.
- R8: `irqOut` is 1 exactly when `ctlIe` is 1 and `intId` is not 0x0000. It follows `ctlIe` in the same cycle.
- R9: `intId` and `pendVec` keep updating while `ctlIe` is 0.
- R10: `pendVec` and `intId` take their new values at the first rising clock edge after the strobe that changes them.
- R11: When a set and a clear hit the same cause in the same cycle, the set wins. This holds for a slot bit and for the status cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slotTxDone | input | NUM_SLOTS | Per-slot transmit-complete strobes |
| slotRxDone | input | NUM_SLOTS | Per-slot receive-complete strobes |
| slotTxIe | input | NUM_SLOTS | Per-slot transmit interrupt enables |
| slotRxIe | input | NUM_SLOTS | Per-slot receive interrupt enables |
| slotClr | input | NUM_SLOTS | CPU clear requests for the slot pending bits |
| statOkUpd | input | 1 | Status update caused by a successful transfer |
| statErrUpd | input | 1 | Status update caused by an error or a state change |
| statAccess | input | 1 | CPU access to the status register |
| statWrite | input | 1 | Qualifies statAccess: 1 means write, 0 means read |
| ctlIe | input | 1 | Global interrupt line enable |
| ctlSie | input | 1 | Enables posting of successful-transfer status updates |
| ctlEie | input | 1 | Enables posting of error status updates |
| intId | output | 16 | Identifier of the highest-priority pending cause |
| pendVec | output | NUM_SLOTS | Slot pending bits |
| irqOut | output | 1 | Interrupt line to the CPU |

## Verification
A set or clear strobe is applied for a single cycle. Both `pendVec` and `intId` must then show its effect after exactly one rising edge, so the bench drives strobes on a falling edge and compares the outputs on the next falling edge. `irqOut` has no register between `ctlIe` and the line, so changes of `ctlIe` are checked a short delay after the input moves, with no clock edge in between. The checks for ignored stimuli (a disabled completion, a disabled status update, a status write) look at `intId` and `pendVec` one edge after the strobe.

// File: rtl/irq_id_pkg.sv
package irq_id_pkg;
  localparam int unsigned ID_W = 16;
  localparam logic [ID_W-1:0] STAT_CODE = 16'h8000;
  localparam logic [ID_W-1:0] NONE_CODE = 16'h0000;

  typedef struct packed {
    logic statSet;
    logic statClr;
  } statStrobe_t;
endpackage

// File: rtl/irq_id_ctrl.sv
module irq_id_ctrl
  import irq_id_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32
) (
  input  logic [NUM_SLOTS-1:0] slotTxDone,
  input  logic [NUM_SLOTS-1:0] slotRxDone,
  input  logic [NUM_SLOTS-1:0] slotTxIe,
  input  logic [NUM_SLOTS-1:0] slotRxIe,
  input  logic [NUM_SLOTS-1:0] slotClr,
  input  logic                 statOkUpd,
  input  logic                 statErrUpd,
  input  logic                 statAccess,
  input  logic                 statWrite,
  input  logic                 ctlSie,
  input  logic                 ctlEie,
  output logic [NUM_SLOTS-1:0] setVec,
  output logic [NUM_SLOTS-1:0] clrVec,
  output statStrobe_t          statStb
);
  // Each slot gates its two completion sources with their own enables.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign setVec[s] = (slotTxDone[s] & slotTxIe[s]) | (slotRxDone[s] & slotRxIe[s]);
    assign clrVec[s] = slotClr[s];
  end

  // A status write can never reach the status cause. Only a read clears it.
  always_comb begin
    statStb.statSet = (statOkUpd & ctlSie) | (statErrUpd & ctlEie);
    statStb.statClr = statAccess & ~statWrite;
  end
endmodule

// File: rtl/irq_id_dp.sv
module irq_id_dp
  import irq_id_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] setVec,
  input  logic [NUM_SLOTS-1:0] clrVec,
  input  statStrobe_t          statStb,
  input  logic                 ctlIe,
  output logic [ID_W-1:0]      intId,
  output logic [NUM_SLOTS-1:0] pendVec,
  output logic                 irqOut
);
  logic [NUM_SLOTS-1:0] pendQ, pendNext;
  logic                 statQ, statNext;
  logic [ID_W-1:0]      idQ, idNext;

  // A set wins over a clear that arrives in the same cycle.
  assign pendNext = (pendQ & ~clrVec) | setVec;
  assign statNext = (statQ & ~statStb.statClr) | statStb.statSet;

  // The identifier is encoded from the next state, so it is registered at the same edge as the pending bits.
  always_comb begin
    idNext = NONE_CODE;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (pendNext[i]) idNext = ID_W'(i + 1);
    end
    if (statNext) idNext = STAT_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ <= '0;
      statQ <= 1'b0;
      idQ   <= NONE_CODE;
    end else begin
      pendQ <= pendNext;
      statQ <= statNext;
      idQ   <= idNext;
    end
  end

  assign intId   = idQ;
  assign pendVec = pendQ;
  assign irqOut  = ctlIe & (idQ != NONE_CODE);
endmodule

// File: rtl/irq_id_top.sv
module irq_id_top
  import irq_id_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slotTxDone,
  input  logic [NUM_SLOTS-1:0] slotRxDone,
  input  logic [NUM_SLOTS-1:0] slotTxIe,
  input  logic [NUM_SLOTS-1:0] slotRxIe,
  input  logic [NUM_SLOTS-1:0] slotClr,
  input  logic                 statOkUpd,
  input  logic                 statErrUpd,
  input  logic                 statAccess,
  input  logic                 statWrite,
  input  logic                 ctlIe,
  input  logic                 ctlSie,
  input  logic                 ctlEie,
  output logic [15:0]          intId,
  output logic [NUM_SLOTS-1:0] pendVec,
  output logic                 irqOut
);
  logic [NUM_SLOTS-1:0] setVec, clrVec;
  statStrobe_t          statStb;

  irq_id_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .slotTxDone(slotTxDone), .slotRxDone(slotRxDone),
    .slotTxIe(slotTxIe), .slotRxIe(slotRxIe), .slotClr(slotClr),
    .statOkUpd(statOkUpd), .statErrUpd(statErrUpd),
    .statAccess(statAccess), .statWrite(statWrite),
    .ctlSie(ctlSie), .ctlEie(ctlEie),
    .setVec(setVec), .clrVec(clrVec), .statStb(statStb)
  );

  irq_id_dp #(.NUM_SLOTS(NUM_SLOTS)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .setVec(setVec), .clrVec(clrVec), .statStb(statStb),
    .ctlIe(ctlIe),
    .intId(intId), .pendVec(pendVec), .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_id_chk.sv
module irq_id_chk #(
  parameter int unsigned NUM_SLOTS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] slotTxDone,
  input logic [NUM_SLOTS-1:0] slotRxDone,
  input logic [NUM_SLOTS-1:0] slotTxIe,
  input logic [NUM_SLOTS-1:0] slotRxIe,
  input logic [NUM_SLOTS-1:0] slotClr,
  input logic                 statOkUpd,
  input logic                 statErrUpd,
  input logic                 statAccess,
  input logic                 statWrite,
  input logic                 ctlIe,
  input logic                 ctlSie,
  input logic                 ctlEie,
  input logic [15:0]          intId,
  input logic [NUM_SLOTS-1:0] pendVec,
  input logic                 irqOut
);
  logic [NUM_SLOTS-1:0] armedMask;
  logic                 statPost;
  assign armedMask = (slotTxDone & slotTxIe) | (slotRxDone & slotRxIe);
  assign statPost  = (statOkUpd & ctlSie) | (statErrUpd & ctlEie);

  AST_SLOT_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    (armedMask != '0) |=> ((pendVec & $past(armedMask)) == $past(armedMask))); // R2

  AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (intId == 16'h0000) || (intId == 16'h8000) || (intId <= 16'(NUM_SLOTS))); // R3

  AST_STATUS_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    statPost |=> (intId == 16'h8000)); // R4

  AST_WRITE_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (intId == 16'h8000 && statAccess && statWrite) |=> (intId == 16'h8000)); // R6

  AST_ZERO_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (intId == 16'h0000) |-> (pendVec == '0)); // R7

  AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut == (ctlIe && (intId != 16'h0000))); // R8
endmodule

bind irq_id_top irq_id_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/test_irq_id_top.sv
module test_irq_id_top;
  localparam int unsigned N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  slotTxDone, slotRxDone, slotTxIe, slotRxIe, slotClr;
  logic          statOkUpd, statErrUpd, statAccess, statWrite;
  logic          ctlIe, ctlSie, ctlEie;
  logic [15:0]   intId;
  logic [N-1:0]  pendVec;
  logic          irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  irq_id_top #(.NUM_SLOTS(N)) i_irq_id_top (.*);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  // Strobes are raised at a falling edge. This moves one rising edge forward and drops them again.
  task automatic step();
    @(negedge clk);
    slotTxDone = '0; slotRxDone = '0; slotClr = '0;
    statOkUpd = 0; statErrUpd = 0; statAccess = 0; statWrite = 0;
  endtask

  task automatic rxSlot(int slot);
    slotRxDone[slot-1] = 1'b1; step();
  endtask

  task automatic clrSlot(int slot);
    slotClr[slot-1] = 1'b1; step();
  endtask

  task automatic testReset();
    check("R1 id in reset", intId, 0);
    check("R1 pend in reset", pendVec, 0);
    check("R1 irq in reset", irqOut, 0);
    rst_n = 1'b1; step();
    check("R1 id after release", intId, 0);
  endtask

  task automatic testEnableGate();
    slotTxIe = '0; slotRxIe = '1;
    slotTxDone[4] = 1'b1; step();
    check("R2 disabled tx ignored", pendVec, 0);
    slotRxDone[4] = 1'b1; step();
    check("R2 rx sets bit 4", pendVec, 32'h10);
    check("R10 id one edge later", intId, 5);
    clrSlot(5);
    check("R7 clear to empty", intId, 0);
  endtask

  task automatic testPriority();
    rxSlot(20); rxSlot(5);
    check("R3 lower slot wins", intId, 5);
    rxSlot(3);
    check("R3 newest lower slot wins", intId, 3);
    clrSlot(3);
    check("R7 next is 5", intId, 5);
    clrSlot(5);
    check("R7 next is 20", intId, 20);
    clrSlot(20);
    check("R7 empty id", intId, 0);
    check("R7 empty pend", pendVec, 0);
    rxSlot(32);
    check("R3 top slot code", intId, 32);
    clrSlot(32);
  endtask

  task automatic testStatus();
    rxSlot(2);
    ctlSie = 0; ctlEie = 0;
    statOkUpd = 1; step();
    check("R5 ok update gated", intId, 2);
    statErrUpd = 1; step();
    check("R5 err update gated", intId, 2);
    ctlSie = 1;
    statOkUpd = 1; step();
    check("R4 status outranks slot", intId, 16'h8000);
    statAccess = 1; statWrite = 1; step();
    check("R6 write keeps status", intId, 16'h8000);
    statAccess = 1; step();
    check("R6 read clears status", intId, 2);
    statAccess = 1; statWrite = 1; step();
    check("R6 write posts nothing", intId, 2);
    ctlSie = 0; ctlEie = 1;
    statErrUpd = 1; step();
    check("R5 err update posts", intId, 16'h8000);
    statAccess = 1; step();
    clrSlot(2);
    check("R7 all clear", intId, 0);
  endtask

  task automatic testLine();
    ctlIe = 1; #1;
    check("R8 idle line low", irqOut, 0);
    step();
    ctlIe = 0;
    rxSlot(9);
    check("R9 id updates with ie low", intId, 9);
    check("R8 line low with ie low", irqOut, 0);
    ctlIe = 1; #1;
    check("R8 line follows ie", irqOut, 1);
    step();
    clrSlot(9);
    check("R8 line drops when empty", irqOut, 0);
  endtask

  task automatic testCollision();
    rxSlot(7);
    slotRxDone[6] = 1'b1; slotClr[6] = 1'b1; step();
    check("R11 slot set beats clear", pendVec, 32'h40);
    clrSlot(7);
    ctlSie = 1;
    statOkUpd = 1; statAccess = 1; step();
    check("R11 status set beats read", intId, 16'h8000);
    statAccess = 1; step();
    check("R11 status then cleared", intId, 0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    slotTxIe = '0; slotRxIe = '0;
    ctlIe = 0; ctlSie = 0; ctlEie = 0;
    slotTxDone = '0; slotRxDone = '0; slotClr = '0;
    statOkUpd = 0; statErrUpd = 0; statAccess = 0; statWrite = 0;
    repeat (3) @(negedge clk);
    testReset();
    testEnableGate();
    testPriority();
    testStatus();
    testLine();
    testCollision();
    done = 1;
    report();
    $finish;
  end
endmodule